// File: doc/BRIEF.md
# Busy-Gated Three-Master Bus Arbiter

This block decides which of three masters may drive a shared bus. Each master raises its own request line and receives its own grant line. A separate busy input reports whether a transaction is currently running on the bus. The arbiter makes a new choice only while busy is low. Once it has given the bus to a master, it keeps that grant in place for the whole transaction. A request from a master of higher rank does not take the bus away.

Rank is fixed by index, and index 0 ranks highest. Grants are registered. A grant appears on the clock edge that samples a request with busy low. A master may withdraw an unanswered request at any time, and the arbiter then never grants it. A master that is granted but drops its request before starting the transaction loses the grant. Arbitration then restarts on the next idle cycle.

The controller has three states:
- ARB_IDLE: no grant is held.
- ARB_OFFER: a grant is held, but the holder has not yet raised busy.
- ARB_HOLD: the holder's transaction is running.

The transitions are:
- ARB_IDLE to ARB_OFFER, on any request with busy low.
- ARB_OFFER to ARB_HOLD, on busy high.
- ARB_OFFER to ARB_IDLE, when the holder withdraws with busy low.
- ARB_HOLD to ARB_OFFER, when busy falls with requests pending. The winner is re-picked.
- ARB_HOLD to ARB_IDLE, when busy falls with no requests.
- Every other case stays in the current state.

Top module: `bus_arb_busy`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears every grant, whatever the requests and busy show.
- R2: At most one bit of gnt is high in any cycle.
- R3: From the idle state, a clock edge that samples busy low and at least one request sets exactly the grant bit of the lowest-numbered requester (bit i of gnt answers bit i of req).
- R4: While no grant is held, an edge that samples busy high issues no grant, whatever the requests.
- R5: Once the holder's transaction is running (busy high), the grant stays unchanged until busy is sampled low, even if the holder drops its request or higher-ranked masters request.
- R6: While a grant is held with busy still low and the holder still requesting, a request from a higher-ranked master does not move the grant.
- R7: A master whose request is withdrawn before any edge samples it together with busy low never receives a grant.
- R8: If the holder drops its request while busy is still low and the transaction has not started, its grant clears on the next edge. The next edge that samples busy low with a request pending then grants by rank.
- R9: When busy is sampled low after a transaction, the grant clears if no request is pending. Otherwise it moves to the lowest-numbered requester on that same edge, and this may be the previous holder or a different master.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk  | input  | 1 | Clock, rising edge active |
| rst  | input  | 1 | Synchronous reset, active high |
| req  | input  | N_MASTERS (3) | Request lines, bit i from master i |
| busy | input  | 1 | High while a transaction occupies the bus |
| gnt  | output | N_MASTERS (3) | Registered grants, bit i to master i, at most one high |

## Verification
The bench drives several kinds of request pattern and checks what each one separates.
- Patterns with all three masters requesting, and with masters 1 and 2 only, check that rank decides the winner rather than arrival order.
- Requests that stay up while busy is high check that arbitration is truly gated. They also check that the running holder is never preempted.
- A request that rises and is withdrawn entirely under busy tells a correct arbiter apart from one that latches requests.
- Patterns where the holder drops its request, both before and after busy rises, separate the early release of R8 from the transaction-length hold of R5.
- Busy falling with and without pending requests shows whether the grant is cleared or passed on within the same edge.

// File: rtl/arb_busy_pkg.sv
package arb_busy_pkg;

    // Controller state encoding
    typedef enum logic [1:0] {
        ARB_IDLE  = 2'd0,   // no grant outstanding
        ARB_OFFER = 2'd1,   // grant held, transaction not yet started
        ARB_HOLD  = 2'd2    // holder's transaction in progress
    } arb_state_e;

endpackage

// File: rtl/arb_prio_pick.sv
// Fixed-rank selector: lowest index that requests wins.
module arb_prio_pick #(
    parameter int N_MASTERS = 3
) (
    input  logic [N_MASTERS-1:0] req,
    output logic [N_MASTERS-1:0] pick,
    output logic                 any_req
);

    // seen[i] is high when some master below index i requests
    logic [N_MASTERS:0] seen;

    assign seen[0] = 1'b0;

    generate
        for (genvar i = 0; i < N_MASTERS; i++) begin : g_rank
            assign pick[i]   = req[i] & ~seen[i];
            assign seen[i+1] = seen[i] | req[i];
        end
    endgenerate

    assign any_req = seen[N_MASTERS];

endmodule

// File: rtl/arb_ctrl_fsm.sv
// State machine owning the grant register.
module arb_ctrl_fsm
    import arb_busy_pkg::*;
#(
    parameter int N_MASTERS = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 busy,
    input  logic [N_MASTERS-1:0] req,
    input  logic [N_MASTERS-1:0] pick,
    input  logic                 any_req,
    output arb_state_e           state,
    output logic [N_MASTERS-1:0] gnt
);

    localparam logic [N_MASTERS-1:0] NO_GRANT = '0;

    arb_state_e           state_nxt;
    logic [N_MASTERS-1:0] gnt_nxt;
    logic                 holder_req;

    // Holder still asserting its own request
    assign holder_req = |(req & gnt);

    always_comb begin
        state_nxt = state;
        gnt_nxt   = gnt;
        unique case (state)
            ARB_IDLE: begin
                if (!busy && any_req) begin
                    state_nxt = ARB_OFFER;
                    gnt_nxt   = pick;
                end else begin
                    gnt_nxt   = NO_GRANT;
                end
            end
            ARB_OFFER: begin
                if (busy) begin
                    state_nxt = ARB_HOLD;
                end else if (!holder_req) begin
                    state_nxt = ARB_IDLE;
                    gnt_nxt   = NO_GRANT;
                end
            end
            ARB_HOLD: begin
                if (!busy) begin
                    if (any_req) begin
                        state_nxt = ARB_OFFER;
                        gnt_nxt   = pick;
                    end else begin
                        state_nxt = ARB_IDLE;
                        gnt_nxt   = NO_GRANT;
                    end
                end
            end
            default: begin
                state_nxt = ARB_IDLE;
                gnt_nxt   = NO_GRANT;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ARB_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (rst) begin
            gnt <= NO_GRANT;
        end else begin
            gnt <= gnt_nxt;
        end
    end

endmodule

// File: rtl/bus_arb_busy.sv
// Top: busy-gated, non-preemptive fixed-rank arbiter.
module bus_arb_busy
    import arb_busy_pkg::*;
#(
    parameter int N_MASTERS = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_MASTERS-1:0] req,
    input  logic                 busy,
    output logic [N_MASTERS-1:0] gnt
);

    logic [N_MASTERS-1:0] pick;
    logic                 any_req;
    arb_state_e           fsm_state;

    arb_prio_pick #(
        .N_MASTERS (N_MASTERS)
    ) u_pick (
        .req     (req),
        .pick    (pick),
        .any_req (any_req)
    );

    arb_ctrl_fsm #(
        .N_MASTERS (N_MASTERS)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .busy    (busy),
        .req     (req),
        .pick    (pick),
        .any_req (any_req),
        .state   (fsm_state),
        .gnt     (gnt)
    );

endmodule

// File: rtl/arb_busy_chk.sv
module arb_busy_chk
    import arb_busy_pkg::*;
#(
    parameter int N_MASTERS = 3
) (
    input logic                 clk,
    input logic                 rst,
    input logic [N_MASTERS-1:0] req,
    input logic                 busy,
    input logic [N_MASTERS-1:0] gnt,
    input arb_state_e           state
);

    localparam logic [N_MASTERS-1:0] ONE = {{(N_MASTERS-1){1'b0}}, 1'b1};

    // R2
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));

    // R3 R7 R9
    new_grant_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (|(gnt & ~$past(gnt))) |->
            (!$past(busy) && (|($past(req) & gnt)) &&
             (($past(req) & (gnt - ONE)) == '0)));

    // R5
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && (gnt != '0)) |=> (gnt == $past(gnt)));

    // R6
    no_preempt_chk: assert property (@(posedge clk) disable iff (rst)
        ((state == ARB_OFFER) && !busy && (|(req & gnt))) |=> $stable(gnt));

    // R8 R9
    idle_release_chk: assert property (@(posedge clk) disable iff (rst)
        ((gnt != '0) && !busy && (req == '0)) |=> (gnt == '0));

    // R4
    busy_gate_chk: assert property (@(posedge clk) disable iff (rst)
        ((gnt == '0) && busy) |=> (gnt == '0));

endmodule

bind bus_arb_busy arb_busy_chk #(
    .N_MASTERS (N_MASTERS)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .req   (req),
    .busy  (busy),
    .gnt   (gnt),
    .state (fsm_state)
);

// File: tb/sim_bus_arb_busy.sv
module sim_bus_arb_busy;

    localparam int CLK_PERIOD = 10;
    localparam int NM         = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NM-1:0] req = '0;
    logic          busy = 1'b0;
    logic [NM-1:0] gnt;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [NM-1:0] exp_q[$];
    string         tag_q[$];

    bus_arb_busy #(.N_MASTERS(NM)) u0 (
        .clk  (clk),
        .rst  (rst),
        .req  (req),
        .busy (busy),
        .gnt  (gnt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Driver: apply inputs for one edge, queue the grant expected after it
    task automatic step(input logic r, input logic [NM-1:0] q, input logic b,
                        input logic [NM-1:0] e, input string tag);
        @(negedge clk);
        rst  = r;
        req  = q;
        busy = b;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // Monitor: compare just after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                automatic logic [NM-1:0] e = exp_q.pop_front();
                automatic string         t = tag_q.pop_front();
                n_run++;
                if (gnt !== e) begin
                    n_fail++;
                    $display("FAIL %s: gnt=%b expected %b", t, gnt, e);
                end
                n_run++;
                if ($countones(gnt) > 1) begin
                    n_fail++;
                    $display("FAIL R2: gnt=%b expected at most one bit", gnt);
                end
            end
        end
    end

    initial begin
        // R1: reset with every master requesting
        step(1'b1, 3'b111, 1'b0, 3'b000, "R1");
        step(1'b1, 3'b111, 1'b0, 3'b000, "R1");
        step(1'b0, 3'b000, 1'b0, 3'b000, "R1");
        // R3: masters 1 and 2 request, master 1 wins
        step(1'b0, 3'b110, 1'b0, 3'b010, "R3");
        // R6: master 0 arrives before busy, no preemption
        step(1'b0, 3'b111, 1'b0, 3'b010, "R6");
        // R5: transaction running, holder drops, others request
        step(1'b0, 3'b111, 1'b1, 3'b010, "R5");
        step(1'b0, 3'b001, 1'b1, 3'b010, "R5");
        // R9: busy falls, master 0 pending
        step(1'b0, 3'b001, 1'b0, 3'b001, "R9");
        // R8: holder withdraws before busy
        step(1'b0, 3'b000, 1'b0, 3'b000, "R8");
        // R4: request under busy while idle
        step(1'b0, 3'b100, 1'b1, 3'b000, "R4");
        step(1'b0, 3'b100, 1'b1, 3'b000, "R4");
        step(1'b0, 3'b100, 1'b0, 3'b100, "R3");
        step(1'b0, 3'b100, 1'b1, 3'b100, "R5");
        step(1'b0, 3'b111, 1'b1, 3'b100, "R5");
        // R9: busy falls, nothing pending
        step(1'b0, 3'b000, 1'b0, 3'b000, "R9");
        // R7: master 1 requests only under busy, then withdraws
        step(1'b0, 3'b010, 1'b1, 3'b000, "R7");
        step(1'b0, 3'b000, 1'b0, 3'b000, "R7");
        step(1'b0, 3'b000, 1'b0, 3'b000, "R7");
        // R8: grant, early drop, re-arbitrate next idle cycle
        step(1'b0, 3'b011, 1'b0, 3'b001, "R3");
        step(1'b0, 3'b010, 1'b0, 3'b000, "R8");
        step(1'b0, 3'b010, 1'b0, 3'b010, "R8");
        // R9: holder still requests, higher rank takes over after busy
        step(1'b0, 3'b011, 1'b1, 3'b010, "R5");
        step(1'b0, 3'b011, 1'b0, 3'b001, "R9");
        // R1: reset during a transaction
        step(1'b0, 3'b011, 1'b1, 3'b001, "R5");
        step(1'b1, 3'b011, 1'b1, 3'b000, "R1");
        step(1'b0, 3'b000, 1'b0, 3'b000, "R1");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule